// File: doc/BRIEF.md
# Bidirectional latched/clocked bus transceiver

This block moves data between two 18-bit ports, A and B, in both directions at once. Each direction has its own storage register. Its latch-enable input selects whether the output follows the input directly (transparent) or shows the stored word. While the latch enable is low, the stored word changes only when that direction's clock input goes from 0 to 1. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The whole block runs on one system clock. The two direction clocks and the latch enables are ordinary inputs that the system clock samples. A direction clock counts as rising when its value at the current system-clock edge is 1 and its value at the previous edge was 0. Three-state drive is represented by a data bus plus an enable bus for each port. An integrator can wrap these in inout pads. When both directions are enabled at the same time, a conflict flag goes high.

Top module: `bidir_xcvr`

## Requirements
- R1: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no register delay. The stored A-to-B word is reloaded from `a_in` at every system-clock edge.
- R2: While `ab_le` is 0 and `ab_clk` does not rise between two system-clock edges, the stored word is unchanged and `b_out` holds it. A 1-to-0 change of `ab_clk` does not load the register.
- R3: When `ab_le` is 0 at a system-clock edge and `ab_clk` is sampled 1 at that edge after being 0 at the previous edge, `a_in` from that edge is stored. It appears on `b_out` right after that edge.
- R4: When `ab_le` falls while `ab_clk` is held at either level, `b_out` keeps the `a_in` value from the last edge at which `ab_le` was 1. Later changes of `a_in` do not reach `b_out`.
- R5: `ab_oe` is active high. When it is 1 every bit of `b_oe` is 1, and when it is 0 every bit is 0.
- R6: `ba_oe_n` is active low and drives `a_oe` with the same all-bits rule as R5. The B-to-A path follows R1 to R4 using `ba_le`, `ba_clk`, `b_in` and `a_out`.
- R7: While `rst_n` is 0, `a_oe` and `b_oe` are all 0, whatever the enables are, and both stored words are cleared at each edge. After reset, with the latch enables low and no clock rise, `a_out` and `b_out` read 0.
- R8: `conflict` is 1 exactly when `b_oe` and `a_oe` are both active. It is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | WIDTH | Data received on port A |
| b_in | input | WIDTH | Data received on port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B capture clock, sampled |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A capture clock, sampled |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | WIDTH | Data driven onto port B |
| b_oe | output | WIDTH | Per-bit drive enable for port B |
| a_out | output | WIDTH | Data driven onto port A |
| a_oe | output | WIDTH | Per-bit drive enable for port A |
| conflict | output | 1 | Both ports driving at once |

## Verification
The bench targets the moment the latch enable falls while the direction clock is held high. A design that took that level for a rising edge would load a new word and break R4. It also checks that a 1-to-0 change of the direction clock loads nothing; a design that captured on both transitions would show fresh data there. A long random sweep compares outputs each cycle against a model built from the requirements, mixing transparent cycles, clock rises and holds. A registered transparent path would show up as a one-cycle lag. Swapped enable polarities or an enable that stayed active during reset fail the R5, R6 and R7 checks.

// File: rtl/bidir_xcvr.sv
module bidir_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_oe,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  output logic             conflict
);

  logic [WIDTH-1:0] ab_q, ba_q;
  logic ab_clk_d, ba_clk_d;
  logic ab_cap, ba_cap;

  assign ab_cap = !ab_le && ab_clk && !ab_clk_d;
  assign ba_cap = !ba_le && ba_clk && !ba_clk_d;

  always_ff @(posedge clk) begin
    ab_clk_d <= ab_clk;
    ba_clk_d <= ba_clk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ab_q <= '0;
    else if (ab_le || ab_cap) ab_q <= a_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ba_q <= '0;
    else if (ba_le || ba_cap) ba_q <= b_in;
  end

  assign b_out    = ab_le ? a_in : ab_q;
  assign a_out    = ba_le ? b_in : ba_q;
  assign b_oe     = {WIDTH{rst_n & ab_oe}};
  assign a_oe     = {WIDTH{rst_n & ~ba_oe_n}};
  assign conflict = b_oe[0] & a_oe[0];

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !$rose(ab_clk)) |=> (ab_le || $stable(b_out))); // R2
  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $rose(ab_clk)) |=> (ab_le || b_out == $past(a_in))); // R3
  AST_AB_LE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |=> (ab_le || $rose(ab_clk) || b_out == $past(a_in))); // R4
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !$rose(ba_clk)) |=> (ba_le || $stable(a_out))); // R6
  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && $rose(ba_clk)) |=> (ba_le || a_out == $past(b_in))); // R6
  AST_B_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe == '0 || &b_oe)); // R5
  AST_A_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe == '0 || &a_oe)); // R6
  AST_RESET_OFF: assert property (@(posedge clk)
    !rst_n |-> (b_oe == '0 && a_oe == '0 && !conflict)); // R7
  AST_CONFLICT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (&b_oe && &a_oe)); // R8
  AST_CONFLICT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|b_oe, |a_oe}) |-> !conflict); // R8

endmodule

// File: tb/test_bidir_xcvr.sv
module test_bidir_xcvr;
  localparam int W = 18;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_oe = 1, ba_le = 0, ba_clk = 0, ba_oe_n = 0;
  logic [W-1:0] b_out, b_oe, a_out, a_oe;
  logic conflict;

  int checks = 0, failures = 0;
  logic [W-1:0] m_ab, m_ba;
  logic p_ab, p_ba;
  logic done = 0;

  always #10 clk = ~clk;

  bidir_xcvr #(.WIDTH(W)) i_bidir_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
    .conflict(conflict));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    @(posedge clk);
    if (!rst_n) begin
      m_ab = '0; m_ba = '0;
    end else begin
      if (ab_le || (ab_clk && !p_ab)) m_ab = a_in;
      if (ba_le || (ba_clk && !p_ba)) m_ba = b_in;
    end
    p_ab = ab_clk; p_ba = ba_clk;
    @(negedge clk);
  endtask

  task automatic check_all();
    #2;
    chk(ab_le ? "R1" : "R2 R3", b_out, ab_le ? a_in : m_ab);
    chk("R6", a_out, ba_le ? b_in : m_ba);
    chk("R5", b_oe, {W{rst_n & ab_oe}});
    chk("R6", a_oe, {W{rst_n & ~ba_oe_n}});
    chk("R8", {{(W-1){1'b0}}, conflict}, {{(W-1){1'b0}}, rst_n & ab_oe & ~ba_oe_n});
  endtask

  initial begin
    m_ab = '0; m_ba = '0; p_ab = 0; p_ba = 0;
    @(negedge clk);
    a_in = 18'h2AAAA; b_in = 18'h15555;
    model_edge();
    model_edge();
    #2;
    chk("R7", b_oe, '0);
    chk("R7", a_oe, '0);
    chk("R7", {{(W-1){1'b0}}, conflict}, '0);
    chk("R7", b_out, '0);
    chk("R7", a_out, '0);
    rst_n = 1;
    model_edge();
    #2;
    chk("R7", b_out, '0);
    chk("R7", a_out, '0);

    ab_le = 1; ba_le = 1; a_in = 18'h3C3C3; b_in = 18'h0F0F0;
    #2;
    chk("R1", b_out, 18'h3C3C3);
    chk("R6", a_out, 18'h0F0F0);
    ab_clk = 1; ba_clk = 1;
    model_edge();
    ab_le = 0; ba_le = 0;
    model_edge();
    a_in = 18'h12345; b_in = 18'h2FEDC;
    #2;
    chk("R4", b_out, 18'h3C3C3);
    chk("R4", a_out, 18'h0F0F0);
    model_edge();
    #2;
    chk("R4", b_out, 18'h3C3C3);
    ab_clk = 0; ba_clk = 0;
    model_edge();
    #2;
    chk("R2", b_out, 18'h3C3C3);
    chk("R2", a_out, 18'h0F0F0);
    ab_clk = 1;
    model_edge();
    #2;
    chk("R3", b_out, 18'h12345);
    chk("R6", a_out, 18'h0F0F0);
    ba_clk = 1;
    model_edge();
    #2;
    chk("R6", a_out, 18'h2FEDC);

    ab_oe = 0; ba_oe_n = 1;
    check_all();
    ab_oe = 1; ba_oe_n = 0;
    check_all();

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      a_in = W'($urandom); b_in = W'($urandom);
      ab_le = ($urandom % 4) == 0;
      ba_le = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) ab_clk = ~ab_clk;
      if (($urandom % 3) == 0) ba_clk = ~ba_clk;
      ab_oe = $urandom % 2;
      ba_oe_n = $urandom % 2;
      if (n == 1500) rst_n = 0;
      if (n == 1504) rst_n = 1;
      check_all();
      model_edge();
    end
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=0 exp=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule